// File: doc/BRIEF.md
# Masked Source/Target ID Event Counter

This block counts request events seen by an interconnect agent, qualified by three things: the event code, the identifiers of the clusters that sent and will receive each request, and the ring channel the request travelled on. Every cycle the agent may present one event made of a valid strobe, an 8-bit event code, an 11-bit source cluster ID, an 11-bit target cluster ID and a flag saying whether the request used the extended channel. A cluster ID holds a 6-bit die-cluster number in bits 10:5 and a 5-bit sub-cluster number in bits 4:0. On I/O dies the sub-cluster codes are 5'b00000 for management, 5'b00001 for network, 5'b00011 for the accelerator and 5'b10000 for PCIe.

Software programs a compare value and an ignore mask for the source ID and another pair for the target ID. It also sets a 2-bit channel selector, the event code to count and the enable bits, all through a simple register port. It then reads back a 48-bit count with a sticky overflow flag. A two-state controller gates counting. ST_IDLE moves to ST_RUN (transition T_START) when the control register is written with the run bit set. ST_RUN moves back to ST_IDLE (transition T_STOP) when it is written with the run bit clear. Any other control write keeps the current state.

Register map (word addresses on a 3-bit address). Address 0 is control: bit 0 is run, bit 1 enables the source match, bit 2 enables the target match, bits 5:4 hold the channel selector and bits 15:8 hold the event code. Address 1 is the source filter and address 2 is the target filter: each has the compare value in bits 10:0 and the mask in bits 26:16. Address 3 is count bits 31:0. Address 4 holds count bits 47:32 in bits 15:0 and the overflow flag in bit 31. Writing address 5 with bit 0 set clears the count and the overflow flag. Unmapped addresses read zero.

Top module: `sid_tid_evcnt`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, the overflow flag reads 0 and the controller is in ST_IDLE.
- R2: While the run bit is 0 (ST_IDLE), no event changes the count.
- R3: In ST_RUN an event counts only if its code equals control bits 15:8. With both match enables clear and the channel selector at 2'b00, every valid event with that code adds one, once per cycle.
- R4: With the source enable set, an event counts only if, for every bit position whose source mask bit is 0, the event's source ID bit equals the compare bit. Mask bits set to 1 are not compared. With the enable clear, the source ID has no effect.
- R5: The target ID is filtered the same way as the source ID, using its own compare value, mask and enable, independently of the source filter.
- R6: For event codes 0x47 to 0x59 inclusive, the channel selector applies. 2'b01 and 2'b11 count only extended-channel events (ev_ext=1). 2'b10 counts only normal-channel events (ev_ext=0). 2'b00 counts events on both channels.
- R7: For event codes outside 0x47 to 0x59, the channel selector has no effect.
- R8: An increment from the all-ones 48-bit count wraps the count to 0 and sets the overflow flag. The flag stays set through later increments until it is cleared.
- R9: Writing address 3 or 4 loads the corresponding count bits. Writing address 5 with bit 0 set clears the count and the overflow flag. A write at the same edge as a counted event takes priority, and that event is dropped.
- R10: rd_data shows, without a clock delay, the register selected by rd_addr in the layout given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data |
| ev_valid | input | 1 | An event is present this cycle |
| ev_code | input | 8 | Event code |
| ev_src | input | 11 | Source cluster ID |
| ev_tgt | input | 11 | Target cluster ID |
| ev_ext | input | 1 | 1 = extended channel, 0 = normal channel |

## Verification
The wrap of the 48-bit count and the sticky overflow flag cannot be reached by feeding events one at a time. The stimulus therefore loads the count to one below all-ones through the register port and then sends a few events across the boundary. The other hard case is a register write landing in the same cycle as a counted event. The bench drives both on the same edge and checks that the loaded value survives. Match and channel cases come from a vector table. Its entries place differences only in masked bits, only in the die field, only in the sub-cluster field, and at both ends of the channel window and just outside it.

// File: rtl/sid_tid_evcnt_pkg.sv
package sid_tid_evcnt_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int ID_W    = 11;
    localparam int EVT_W   = 8;
    localparam int CNT_W   = 48;
    localparam int SEL_W   = 2;
    localparam int MSK_LSB = 16;

    localparam logic [EVT_W-1:0] CHAN_WIN_LO = 8'h47;
    localparam logic [EVT_W-1:0] CHAN_WIN_HI = 8'h59;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SRC   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TGT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNTLO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNTHI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [EVT_W-1:0] code;
        logic [SEL_W-1:0] chan_sel;
        logic             tgt_en;
        logic             src_en;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/sid_tid_idmatch.sv
module sid_tid_idmatch #(
    parameter int ID_W = 11
) (
    input  logic            en,
    input  logic [ID_W-1:0] cmp,
    input  logic [ID_W-1:0] msk,
    input  logic [ID_W-1:0] id,
    output logic            pass
);
    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (id ^ cmp) & ~msk;
        pass = !en || (diff == '0);
    end
endmodule

// File: rtl/sid_tid_chanfilt.sv
module sid_tid_chanfilt #(
    parameter int                EVT_W  = 8,
    parameter int                SEL_W  = 2,
    parameter logic [EVT_W-1:0]  WIN_LO = 8'h47,
    parameter logic [EVT_W-1:0]  WIN_HI = 8'h59
) (
    input  logic [EVT_W-1:0] code,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext,
    output logic             pass
);
    logic in_win;
    logic ch_ok;

    always_comb begin
        in_win = (code >= WIN_LO) && (code <= WIN_HI);
        unique case (sel)
            2'b00:        ch_ok = 1'b1;
            2'b01, 2'b11: ch_ok = ext;
            2'b10:        ch_ok = !ext;
            default:      ch_ok = 1'b1;
        endcase
        pass = !in_win || ch_ok;
    end
endmodule

// File: rtl/sid_tid_counter.sv
module sid_tid_counter #(
    parameter int CNT_W = 48,
    parameter int LO_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_lo,
    input  logic             load_hi,
    input  logic [LO_W-1:0]  load_data,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam int HI_W = CNT_W - LO_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (load_lo || load_hi) begin
            if (load_lo) cnt[LO_W-1:0]     <= load_data;
            if (load_hi) cnt[CNT_W-1:LO_W] <= load_data[HI_W-1:0];
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (&cnt) ovf <= 1'b1;
        end
    end

    p_wrap_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !load_lo && !load_hi && (&cnt)) |=> (cnt == '0 && ovf));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/sid_tid_evcnt.sv
module sid_tid_evcnt
    import sid_tid_evcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ev_valid,
    input  logic [EVT_W-1:0]  ev_code,
    input  logic [ID_W-1:0]   ev_src,
    input  logic [ID_W-1:0]   ev_tgt,
    input  logic              ev_ext
);
    localparam int NFILT = 2;

    run_state_e      state_q, state_d;
    ctrl_t           ctrl_q;
    logic [ID_W-1:0] cmp_q [NFILT];
    logic [ID_W-1:0] msk_q [NFILT];
    logic [ID_W-1:0] ev_id [NFILT];
    logic            en_f  [NFILT];
    logic            id_ok [NFILT];
    logic            chan_ok;
    logic            count_en;
    logic            hit;
    logic            wr_ctrl, wr_clr, wr_lo, wr_hi;
    logic [CNT_W-1:0] cnt;
    logic            ovf;
    logic            unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        wr_lo   = wr_en && (wr_addr == A_CNTLO);
        wr_hi   = wr_en && (wr_addr == A_CNTHI);
        wr_clr  = wr_en && (wr_addr == A_CMD) && wr_data[0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        count_en = 1'b0;
        unique case (state_q)
            ST_IDLE: if (wr_ctrl && wr_data[0])  state_d = ST_RUN;   // T_START
            ST_RUN: begin
                count_en = 1'b1;
                if (wr_ctrl && !wr_data[0])      state_d = ST_IDLE;  // T_STOP
            end
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < NFILT; i++) begin
                cmp_q[i] <= '0;
                msk_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                ctrl_q.run      <= wr_data[0];
                ctrl_q.src_en   <= wr_data[1];
                ctrl_q.tgt_en   <= wr_data[2];
                ctrl_q.chan_sel <= wr_data[5:4];
                ctrl_q.code     <= wr_data[8 +: EVT_W];
            end
            for (int i = 0; i < NFILT; i++) begin
                if (wr_addr == A_SRC + ADDR_W'(i)) begin
                    cmp_q[i] <= wr_data[ID_W-1:0];
                    msk_q[i] <= wr_data[MSK_LSB +: ID_W];
                end
            end
        end
    end

    assign ev_id[0] = ev_src;
    assign ev_id[1] = ev_tgt;
    assign en_f[0]  = ctrl_q.src_en;
    assign en_f[1]  = ctrl_q.tgt_en;

    for (genvar g = 0; g < NFILT; g++) begin : g_idm
        sid_tid_idmatch #(.ID_W(ID_W)) u_match (
            .en   (en_f[g]),
            .cmp  (cmp_q[g]),
            .msk  (msk_q[g]),
            .id   (ev_id[g]),
            .pass (id_ok[g])
        );
    end

    sid_tid_chanfilt #(
        .EVT_W (EVT_W),
        .SEL_W (SEL_W),
        .WIN_LO(CHAN_WIN_LO),
        .WIN_HI(CHAN_WIN_HI)
    ) u_chan (
        .code (ev_code),
        .sel  (ctrl_q.chan_sel),
        .ext  (ev_ext),
        .pass (chan_ok)
    );

    assign hit = count_en && ev_valid && (ev_code == ctrl_q.code)
               && id_ok[0] && id_ok[1] && chan_ok;

    sid_tid_counter #(.CNT_W(CNT_W), .LO_W(REG_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wr_clr),
        .load_lo   (wr_lo),
        .load_hi   (wr_hi),
        .load_data (wr_data),
        .inc       (hit),
        .cnt       (cnt),
        .ovf       (ovf)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[0]           = ctrl_q.run;
                rd_data[1]           = ctrl_q.src_en;
                rd_data[2]           = ctrl_q.tgt_en;
                rd_data[5:4]         = ctrl_q.chan_sel;
                rd_data[8 +: EVT_W]  = ctrl_q.code;
            end
            A_SRC, A_TGT: begin
                rd_data[ID_W-1:0]       = cmp_q[rd_addr == A_TGT];
                rd_data[MSK_LSB +: ID_W] = msk_q[rd_addr == A_TGT];
            end
            A_CNTLO: rd_data = cnt[REG_W-1:0];
            A_CNTHI: begin
                rd_data[CNT_W-REG_W-1:0] = cnt[CNT_W-1:REG_W];
                rd_data[REG_W-1]         = ovf;
            end
            default: rd_data = '0;
        endcase
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_en) |=> $stable(cnt));

    p_code_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code != ctrl_q.code && !wr_en) |=> $stable(cnt));

    p_chan_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code >= CHAN_WIN_LO && ev_code <= CHAN_WIN_HI && ctrl_q.chan_sel == 2'b10
         && ev_ext && !wr_en) |=> $stable(cnt));

    p_run_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) == ctrl_q.run);
endmodule

// File: tb/sid_tid_evcnt_tb_top.sv
module sid_tid_evcnt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic [10:0] ev_src = '0;
    logic [10:0] ev_tgt = '0;
    logic        ev_ext = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sid_tid_evcnt dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_src(ev_src), .ev_tgt(ev_tgt), .ev_ext(ev_ext)
    );

    typedef struct packed {
        logic        src_en;
        logic        tgt_en;
        logic [1:0]  sel;
        logic [7:0]  code;
        logic [10:0] scmp;
        logic [10:0] smsk;
        logic [10:0] tcmp;
        logic [10:0] tmsk;
        logic [7:0]  ecode;
        logic [10:0] esrc;
        logic [10:0] etgt;
        logic        eext;
        logic        exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R3: code compare only
        '{1'b0,1'b0,2'b00,8'h10,11'h000,11'h000,11'h000,11'h000,8'h10,11'h123,11'h456,1'b0,1'b1},
        '{1'b0,1'b0,2'b00,8'h10,11'h000,11'h000,11'h000,11'h000,8'h11,11'h123,11'h456,1'b0,1'b0},
        // R4: full and masked source compare
        '{1'b1,1'b0,2'b00,8'h20,11'h7C3,11'h000,11'h000,11'h000,8'h20,11'h7C3,11'h000,1'b0,1'b1},
        '{1'b1,1'b0,2'b00,8'h20,11'h7C3,11'h000,11'h000,11'h000,8'h20,11'h7C2,11'h000,1'b0,1'b0},
        '{1'b1,1'b0,2'b00,8'h20,11'h040,11'h01F,11'h000,11'h000,8'h20,11'h050,11'h000,1'b0,1'b1},
        '{1'b1,1'b0,2'b00,8'h20,11'h040,11'h01F,11'h000,11'h000,8'h20,11'h090,11'h000,1'b0,1'b0},
        // R5: target compare, die field ignored
        '{1'b0,1'b1,2'b00,8'h30,11'h000,11'h000,11'h003,11'h7E0,8'h30,11'h000,11'h7E3,1'b0,1'b1},
        '{1'b0,1'b1,2'b00,8'h30,11'h000,11'h000,11'h003,11'h7E0,8'h30,11'h000,11'h001,1'b0,1'b0},
        '{1'b1,1'b1,2'b00,8'h30,11'h021,11'h000,11'h010,11'h000,8'h30,11'h021,11'h011,1'b0,1'b0},
        '{1'b0,1'b1,2'b00,8'h30,11'h021,11'h000,11'h010,11'h000,8'h30,11'h7FF,11'h010,1'b0,1'b1},
        // R6: channel window edges
        '{1'b0,1'b0,2'b01,8'h47,11'h000,11'h000,11'h000,11'h000,8'h47,11'h000,11'h000,1'b1,1'b1},
        '{1'b0,1'b0,2'b11,8'h47,11'h000,11'h000,11'h000,11'h000,8'h47,11'h000,11'h000,1'b0,1'b0},
        '{1'b0,1'b0,2'b10,8'h59,11'h000,11'h000,11'h000,11'h000,8'h59,11'h000,11'h000,1'b0,1'b1},
        '{1'b0,1'b0,2'b10,8'h59,11'h000,11'h000,11'h000,11'h000,8'h59,11'h000,11'h000,1'b1,1'b0},
        '{1'b0,1'b0,2'b00,8'h50,11'h000,11'h000,11'h000,11'h000,8'h50,11'h000,11'h000,1'b1,1'b1},
        '{1'b0,1'b0,2'b00,8'h50,11'h000,11'h000,11'h000,11'h000,8'h50,11'h000,11'h000,1'b0,1'b1},
        // R7: just outside the window
        '{1'b0,1'b0,2'b10,8'h46,11'h000,11'h000,11'h000,11'h000,8'h46,11'h000,11'h000,1'b1,1'b1},
        '{1'b0,1'b0,2'b01,8'h5A,11'h000,11'h000,11'h000,11'h000,8'h5A,11'h000,11'h000,1'b0,1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ev(input logic [7:0] c, input logic [10:0] s, input logic [10:0] t,
                      input logic x, input int cycles);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = c; ev_src = s; ev_tgt = t; ev_ext = x;
        repeat (cycles) @(negedge clk);
        ev_valid = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic run, input logic se, input logic te,
                                              input logic [1:0] sel, input logic [7:0] c);
        return {16'h0, c, 2'b00, sel, 1'b0, te, se, run};
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, r); check("R1 ctrl", 64'(r), 64'h0);
        rd(3'd3, r); check("R1 count low", 64'(r), 64'h0);
        rd(3'd4, r); check("R1 count high/ovf", 64'(r), 64'h0);

        // R2 stopped: configure everything but run
        wr(3'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'b00, 8'h10));
        ev(8'h10, 11'h0, 11'h0, 1'b0, 3);
        rd(3'd3, r); check("R2 idle no count", 64'(r), 64'h0);

        // R10 readback of filter registers
        wr(3'd1, {5'h0, 11'h5A5, 5'h0, 11'h2C3});
        wr(3'd2, {5'h0, 11'h00F, 5'h0, 11'h7E1});
        rd(3'd1, r); check("R10 src reg", 64'(r), 64'h05A5_02C3);
        rd(3'd2, r); check("R10 tgt reg", 64'(r), 64'h000F_07E1);
        wr(3'd0, ctrl_word(1'b1, 1'b1, 1'b0, 2'b10, 8'h4C));
        rd(3'd0, r); check("R10 ctrl reg", 64'(r), 64'h0000_4C23);
        rd(3'd7, r); check("R10 unmapped", 64'(r), 64'h0);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(3'd5, 32'h1);
            wr(3'd1, {5'h0, v.smsk, 5'h0, v.scmp});
            wr(3'd2, {5'h0, v.tmsk, 5'h0, v.tcmp});
            wr(3'd0, ctrl_word(1'b1, v.src_en, v.tgt_en, v.sel, v.code));
            ev(v.ecode, v.esrc, v.etgt, v.eext, 1);
            rd(3'd3, r);
            check($sformatf("R3-vector %0d (R4 R5 R6 R7 filters)", i), 64'(r), 64'(v.exp));
        end

        // R3 multi-cycle count, filters off
        wr(3'd5, 32'h1);
        wr(3'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'b00, 8'h10));
        ev(8'h10, 11'h1, 11'h2, 1'b1, 5);
        rd(3'd3, r); check("R3 five back-to-back", 64'(r), 64'd5);

        // R2 stop again, then events ignored
        wr(3'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'b00, 8'h10));
        ev(8'h10, 11'h1, 11'h2, 1'b1, 2);
        rd(3'd3, r); check("R2 stopped after run", 64'(r), 64'd5);

        // R9 write wins over simultaneous event
        wr(3'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'b00, 8'h10));
        @(negedge clk);
        ev_valid = 1'b1; ev_code = 8'h10; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd100;
        @(negedge clk);
        ev_valid = 1'b0; wr_en = 1'b0;
        rd(3'd3, r); check("R9 load beats event", 64'(r), 64'd100);

        // R8 wrap and sticky overflow
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd4, 32'h0000_FFFF);
        rd(3'd4, hi); check("R9 load high", 64'(hi), 64'h0000_FFFF);
        ev(8'h10, 11'h0, 11'h0, 1'b0, 1);
        rd(3'd3, r); rd(3'd4, hi);
        check("R8 all ones no ovf", {hi, r}, 64'h0000_FFFF_FFFF_FFFF);
        ev(8'h10, 11'h0, 11'h0, 1'b0, 1);
        rd(3'd3, r); rd(3'd4, hi);
        check("R8 wrap sets ovf", {hi, r}, 64'h8000_0000_0000_0000);
        ev(8'h10, 11'h0, 11'h0, 1'b0, 1);
        rd(3'd3, r); rd(3'd4, hi);
        check("R8 ovf sticky", {hi, r}, 64'h8000_0000_0000_0001);

        // R9 clear
        wr(3'd5, 32'h1);
        rd(3'd3, r); rd(3'd4, hi);
        check("R9 clear", {hi, r}, 64'h0);
        wr(3'd5, 32'h0);
        rd(3'd3, r); check("R9 cmd bit0 clear no effect", 64'(r), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule